// File: doc/BRIEF.md
# Interrupt Priority Level Masking Unit

This block sits between a set of interrupt request lines and a processor core. It sees seven request lines, and each line carries a fixed priority: line bit `k` is priority level `k+1`, so bit 6 is level 7. Each line has its own enable bit. The enable register resets to all-disabled, so a line that is never configured cannot raise a request.

The block compares the pending, enabled levels against the 3-bit mask level taken from the processor status. It reports the highest level above that mask on `ipl_out`, where 0 means nothing is pending. Level 7 is the exception. It is captured on a rising edge and held until it is acknowledged, and the status mask cannot block it.

While the core is in low-power mode, a separate wakeup threshold register decides whether a pending level may wake the part. Any value written to it above 6 is stored as 6, so a level-7 event can always wake the part.

When the core acknowledges an interrupt, it pulses `ack_stb` and gives the level it is servicing. A small response state machine checks whether a source is still pending at that level. One cycle later it answers either valid or spurious.

The state machine has three states:
- `ACK_IDLE`: no response.
- `ACK_VALID`: a pending source was found.
- `ACK_SPUR`: no source was found.

Its transitions are the same from every state:
- An acknowledge that finds a source goes to `ACK_VALID`.
- An acknowledge that finds none goes to `ACK_SPUR`.
- A cycle with no acknowledge goes to `ACK_IDLE`.

Software can avoid the spurious case for levels 1 to 6. It raises the status mask above a level before it clears that level's enable bit.

Top module: `ipl_mask_unit`

## Requirements
- R1: While `rst` is high, and afterwards until the enables are written, `ipl_out` = 0, `wake_out` = 0 and `ack_done` = 0. With every enable bit still at its reset value 0, no activity on `irq_in` raises `ipl_out` or `wake_out`.
- R2: Levels 1 to 6 are level-sensitive. `irq_in[k]` with enable bit `src_en[k]` set makes level `k+1` pending. `ipl_out` is the highest pending level that is above `sr_mask`.
- R3: A pending level from 1 to 6 that is less than or equal to `sr_mask` is not reported. `ipl_out` shows the next lower qualifying level, or 0 if there is none.
- R4: Level 7 is latched on a rising edge of `irq_in[6]` while `src_en[6]` = 1. It is reported as 7 even when `sr_mask` = 7. Holding `irq_in[6]` high does not latch it again. Clearing `src_en[6]` discards a latched request.
- R5: An acknowledge at level 7 that is answered valid clears the latched level-7 request.
- R6: The cycle after `ack_stb` = 1, `ack_done` = 1. `ack_spur` = 0 if level `ack_lvl` was pending in the strobe cycle.
- R7: If no source is pending at `ack_lvl` in the strobe cycle, the response has `ack_spur` = 1. This includes `ack_lvl` = 0 and a source whose enable was cleared after it was reported.
- R8: A value written to the wakeup threshold is limited to 6. After writing 7, a level-6 request does not wake the part, but a level-7 edge does.
- R9: `wake_out` = 1 only while `low_power` = 1 and some pending level is strictly greater than the wakeup threshold. `sr_mask` has no effect on `wake_out`.
- R10: All outputs are registered. A change in the pending set or in `sr_mask` appears on `ipl_out` one clock later. A write to the enables or the threshold takes effect from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 7 | Raw request lines; bit k is level k+1 |
| sr_mask | input | 3 | Current status mask level |
| src_en_wr | input | 1 | Write strobe for the enable bits |
| src_en_din | input | 7 | New enable bits |
| wk_lvl_wr | input | 1 | Write strobe for the wakeup threshold |
| wk_lvl_din | input | 3 | New wakeup threshold (stored limited to 6) |
| low_power | input | 1 | Core is in low-power mode |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| ipl_out | output | 3 | Highest pending unmasked level, 0 if none |
| wake_out | output | 1 | Wakeup request |
| ack_done | output | 1 | Acknowledge response present |
| ack_spur | output | 1 | Response is spurious |

## Verification
Several properties are checked on every cycle:
- A reported level from 1 to 6 always lies above the previous cycle's mask.
- A latched level 7 always appears on `ipl_out` and, in low-power mode, on `wake_out`.
- A valid level-7 acknowledge clears the latch.
- Wakeup never appears outside low-power mode.
- Every response follows a strobe, and a valid response needs a source that was pending.

Some behaviour only the directed scenarios can show:
- The exact priority chosen among mixed requests.
- The spurious answer after an enable is removed.
- The limiting of a threshold write of 7.
- The absence of a second latch while level 7 stays high.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
    localparam int DEF_NUM_LVL = 7;

    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_VALID = 2'd1,
        ACK_SPUR  = 2'd2
    } ack_state_e;
endpackage

// File: rtl/ipl_src_stage.sv
module ipl_src_stage #(
    parameter int NUM_LVL = ipl_pkg::DEF_NUM_LVL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] raw,
    input  logic               en_wr,
    input  logic [NUM_LVL-1:0] en_din,
    input  logic               clr_top,
    output logic [NUM_LVL-1:0] pend
);
    localparam int TOP = NUM_LVL - 1;

    logic [NUM_LVL-1:0] en_q;
    logic               prev_q;
    logic               top_q;
    logic               top_edge;

    // enable register, all sources off after reset
    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (en_wr) en_q <= en_din;
    end

    assign top_edge = raw[TOP] & ~prev_q;

    // edge capture for the top level; a fresh edge beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            top_q  <= 1'b0;
        end else begin
            prev_q <= raw[TOP];
            top_q  <= en_q[TOP] & (top_edge | (top_q & ~clr_top));
        end
    end

    generate
        for (genvar k = 0; k < TOP; k++) begin : g_lvl
            assign pend[k] = raw[k] & en_q[k];
        end
    endgenerate
    assign pend[TOP] = top_q;

    AST_TOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_top && !top_edge) |=> !top_q);                          // R5
    AST_TOP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !en_q[TOP] |=> !top_q);                                      // R4
endmodule

// File: rtl/ipl_prio.sv
module ipl_prio #(
    parameter  int NUM_LVL = ipl_pkg::DEF_NUM_LVL,
    localparam int LW      = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] pend,
    input  logic [LW-1:0]      sr_mask,
    input  logic               low_power,
    input  logic               wk_wr,
    input  logic [LW-1:0]      wk_din,
    output logic [LW-1:0]      ipl_q,
    output logic               wake_q
);
    localparam logic [LW-1:0] TOP_L  = LW'(NUM_LVL);
    localparam logic [LW-1:0] MAX_WK = LW'(NUM_LVL - 1);

    logic [LW-1:0] wk_lvl_q;
    logic [LW-1:0] best;
    logic          wk_hit;

    always_ff @(posedge clk) begin
        if (rst)        wk_lvl_q <= '0;
        else if (wk_wr) wk_lvl_q <= (wk_din > MAX_WK) ? MAX_WK : wk_din;
    end

    // ascending scan: the last qualifying level wins
    always_comb begin
        best   = '0;
        wk_hit = 1'b0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (pend[i] && ((LW'(i + 1) > sr_mask) || (LW'(i + 1) == TOP_L)))
                best = LW'(i + 1);
            if (pend[i] && (LW'(i + 1) > wk_lvl_q))
                wk_hit = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ipl_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            ipl_q  <= best;
            wake_q <= low_power & wk_hit;
        end
    end

    AST_IPL_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        (ipl_q != '0 && ipl_q != TOP_L) |-> (ipl_q > $past(sr_mask))); // R3
    AST_TOP_ALWAYS_SEEN: assert property (@(posedge clk) disable iff (rst)
        pend[NUM_LVL-1] |=> (ipl_q == TOP_L));                         // R4
    AST_TOP_WAKES: assert property (@(posedge clk) disable iff (rst)
        (low_power && pend[NUM_LVL-1]) |=> wake_q);                    // R8
    AST_WAKE_NEEDS_LP: assert property (@(posedge clk) disable iff (rst)
        wake_q |-> $past(low_power));                                  // R9
endmodule

// File: rtl/ipl_ack_fsm.sv
module ipl_ack_fsm #(
    parameter  int NUM_LVL = ipl_pkg::DEF_NUM_LVL,
    localparam int LW      = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_stb,
    input  logic [LW-1:0]      ack_lvl,
    input  logic [NUM_LVL-1:0] pend,
    output logic               ack_done,
    output logic               ack_spur
);
    import ipl_pkg::*;

    ack_state_e state_q, state_d;
    logic       src_hit;

    always_comb begin
        src_hit = 1'b0;
        for (int i = 0; i < NUM_LVL; i++)
            if (ack_lvl == LW'(i + 1) && pend[i]) src_hit = 1'b1;
    end

    always_comb begin
        unique case (state_q)
            ACK_IDLE, ACK_VALID, ACK_SPUR:
                state_d = ack_stb ? (src_hit ? ACK_VALID : ACK_SPUR) : ACK_IDLE;
            default: state_d = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ACK_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        ack_done = (state_q != ACK_IDLE);
        ack_spur = (state_q == ACK_SPUR);
    end

    AST_RESP_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
        ack_done |-> $past(ack_stb));                                // R6
    AST_VALID_HAD_SRC: assert property (@(posedge clk) disable iff (rst)
        (ack_done && !ack_spur) |-> ($past(pend) != '0));            // R6
    AST_LVL0_SPUR: assert property (@(posedge clk) disable iff (rst)
        (ack_stb && ack_lvl == '0) |=> ack_spur);                    // R7
endmodule

// File: rtl/ipl_mask_unit.sv
module ipl_mask_unit #(
    parameter  int NUM_LVL = ipl_pkg::DEF_NUM_LVL,
    localparam int LW      = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_LVL-1:0] irq_in,
    input  logic [LW-1:0]      sr_mask,
    input  logic               src_en_wr,
    input  logic [NUM_LVL-1:0] src_en_din,
    input  logic               wk_lvl_wr,
    input  logic [LW-1:0]      wk_lvl_din,
    input  logic               low_power,
    input  logic               ack_stb,
    input  logic [LW-1:0]      ack_lvl,
    output logic [LW-1:0]      ipl_out,
    output logic               wake_out,
    output logic               ack_done,
    output logic               ack_spur
);
    logic [NUM_LVL-1:0] pend;
    logic               clr_top;

    assign clr_top = ack_stb && (ack_lvl == LW'(NUM_LVL)) && pend[NUM_LVL-1];

    ipl_src_stage #(.NUM_LVL(NUM_LVL)) u_src (
        .clk    (clk),
        .rst    (rst),
        .raw    (irq_in),
        .en_wr  (src_en_wr),
        .en_din (src_en_din),
        .clr_top(clr_top),
        .pend   (pend)
    );

    ipl_prio #(.NUM_LVL(NUM_LVL)) u_prio (
        .clk      (clk),
        .rst      (rst),
        .pend     (pend),
        .sr_mask  (sr_mask),
        .low_power(low_power),
        .wk_wr    (wk_lvl_wr),
        .wk_din   (wk_lvl_din),
        .ipl_q    (ipl_out),
        .wake_q   (wake_out)
    );

    ipl_ack_fsm #(.NUM_LVL(NUM_LVL)) u_ack (
        .clk     (clk),
        .rst     (rst),
        .ack_stb (ack_stb),
        .ack_lvl (ack_lvl),
        .pend    (pend),
        .ack_done(ack_done),
        .ack_spur(ack_spur)
    );

    AST_SPUR_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
        ack_spur |-> ack_done);                                      // R7
endmodule

// File: tb/test_ipl_mask_unit.sv
module test_ipl_mask_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] irq_in = '0;
    logic [2:0] sr_mask = '0;
    logic       src_en_wr = 1'b0;
    logic [6:0] src_en_din = '0;
    logic       wk_lvl_wr = 1'b0;
    logic [2:0] wk_lvl_din = '0;
    logic       low_power = 1'b0;
    logic       ack_stb = 1'b0;
    logic [2:0] ack_lvl = '0;
    logic [2:0] ipl_out;
    logic       wake_out, ack_done, ack_spur;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    ipl_mask_unit i_ipl_mask_unit (
        .clk(clk), .rst(rst), .irq_in(irq_in), .sr_mask(sr_mask),
        .src_en_wr(src_en_wr), .src_en_din(src_en_din),
        .wk_lvl_wr(wk_lvl_wr), .wk_lvl_din(wk_lvl_din),
        .low_power(low_power), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
        .ipl_out(ipl_out), .wake_out(wake_out),
        .ack_done(ack_done), .ack_spur(ack_spur)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_en(input logic [6:0] v);
        src_en_din = v; src_en_wr = 1'b1;
        tick(1);
        src_en_wr = 1'b0;
    endtask

    task automatic wr_wk(input logic [2:0] v);
        wk_lvl_din = v; wk_lvl_wr = 1'b1;
        tick(1);
        wk_lvl_wr = 1'b0;
    endtask

    task automatic do_ack(input logic [2:0] lvl, input int exp_spur, input string req);
        ack_stb = 1'b1; ack_lvl = lvl;
        tick(1);
        ack_stb = 1'b0;
        chk({req, " ack_done"}, int'(ack_done), 1);
        chk({req, " ack_spur"}, int'(ack_spur), exp_spur);
    endtask

    task automatic report;
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset;
        tick(3);
        chk("R1 ipl in reset", int'(ipl_out), 0);
        chk("R1 wake in reset", int'(wake_out), 0);
        chk("R1 ack_done in reset", int'(ack_done), 0);
        rst = 1'b0;
        low_power = 1'b1;
        irq_in = 7'h7F;
        tick(3);
        chk("R1 no enable ipl", int'(ipl_out), 0);
        chk("R1 no enable wake", int'(wake_out), 0);
        irq_in = '0; low_power = 1'b0;
        tick(2);
    endtask

    task automatic t_levels;
        wr_en(7'h3F);
        sr_mask = 3'd0;
        irq_in = 7'b0000101;
        tick(1);
        chk("R10 one-cycle latency lvl3", int'(ipl_out), 3);
        irq_in = 7'b0010010;
        tick(1);
        chk("R2 highest of 2,5", int'(ipl_out), 5);
        irq_in = 7'b0100000;
        tick(1);
        chk("R2 level 6", int'(ipl_out), 6);
        irq_in = '0;
        tick(1);
        chk("R2 none pending", int'(ipl_out), 0);
    endtask

    task automatic t_mask;
        irq_in = 7'b0011111;
        sr_mask = 3'd3; tick(1);
        chk("R3 mask3 lvl1-5", int'(ipl_out), 5);
        sr_mask = 3'd5; tick(1);
        chk("R3 mask equal top", int'(ipl_out), 0);
        irq_in = 7'b0001111;
        sr_mask = 3'd4; tick(1);
        chk("R3 mask4 lvl1-4", int'(ipl_out), 0);
        sr_mask = 3'd2; tick(1);
        chk("R3 mask2 lvl1-4", int'(ipl_out), 4);
        irq_in = '0; sr_mask = 3'd0; tick(1);
    endtask

    task automatic t_level7;
        wr_en(7'h7F);
        sr_mask = 3'd7;
        irq_in = 7'h40;
        tick(2);
        chk("R4 level7 at mask7", int'(ipl_out), 7);
        do_ack(3'd7, 0, "R6 level7");
        tick(1);
        chk("R5 level7 cleared", int'(ipl_out), 0);
        tick(2);
        chk("R4 held high no relatch", int'(ipl_out), 0);
        irq_in = '0; tick(1);
        irq_in = 7'h40; tick(2);
        chk("R4 second edge", int'(ipl_out), 7);
        wr_en(7'h3F);
        tick(3);
        chk("R4 disable discards", int'(ipl_out), 0);
        do_ack(3'd7, 1, "R7 level7 discarded");
        irq_in = '0; sr_mask = 3'd0; tick(1);
    endtask

    task automatic t_spurious;
        wr_en(7'h7F);
        irq_in = 7'b0000100;
        tick(1);
        chk("R2 level3 pending", int'(ipl_out), 3);
        do_ack(3'd3, 0, "R6 level3");
        src_en_din = 7'h7B; src_en_wr = 1'b1;
        tick(1);
        src_en_wr = 1'b0;
        do_ack(3'd3, 1, "R7 masked before ack");
        do_ack(3'd0, 1, "R7 level0");
        irq_in = '0; tick(1);
        chk("R6 response one cycle", int'(ack_done), 0);
    endtask

    task automatic t_wakeup;
        wr_en(7'h7F);
        sr_mask = 3'd7;
        irq_in = 7'b0001000;
        wr_wk(3'd3);
        tick(1);
        chk("R9 no wake outside low power", int'(wake_out), 0);
        low_power = 1'b1; tick(1);
        chk("R9 4 above threshold 3", int'(wake_out), 1);
        wr_wk(3'd4); tick(1);
        chk("R9 4 not above 4", int'(wake_out), 0);
        wr_wk(3'd7);
        irq_in = 7'b0100000; tick(2);
        chk("R8 clamp blocks level6", int'(wake_out), 0);
        irq_in = 7'b1100000; tick(2);
        chk("R8 level7 wakes", int'(wake_out), 1);
        do_ack(3'd7, 0, "R5 wake level7");
        irq_in = '0; low_power = 1'b0; tick(2);
        chk("R9 idle no wake", int'(wake_out), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_levels;
        t_mask;
        t_level7;
        t_spurious;
        t_wakeup;
        report;
    end

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        report;
    end
endmodule